// File: doc/BRIEF.md
# Flash Command Interpreter with Behavioural Cell Array

This block models a small flash memory together with the command logic that controls it. A host drives 8-bit command codes on the low byte of the write data bus and raises a write strobe. Most of the time the block is in read mode, and the array word selected by the address port appears on the read data port. Changing the array takes two writes. A set-up command arms the operation, and the write that comes straight after it carries the operation itself. Any other order drops the sequence without touching the array.

The array is built from flip-flops. It behaves like flash: the erased value of every bit is 1, and a program can only clear bits, because the stored word is ANDed with the supplied data. An erase restores ones to a single sector, which is selected by the upper address bits, or to the whole array. After an operation a busy timer runs for a fixed number of cycles, and the block ignores all writes while it runs. Two verify commands capture an address and compare its word against the expected result: all ones for an erase, or the last programmed data for a program.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, `mode` is 0, `busy` is 0, `verify_ok` is 0 and every array word reads as all ones.
- R2: `mode` is 0 (read), 1 (erase armed) or 2 (program armed). In these modes `rdata` shows the word at `addr` combinationally, in the same cycle.
- R3: A write of code 0x40 followed by a write on the very next accepted cycle programs the word at that second write's `addr`. The new word is the old word ANDed with that write's `wdata`, so no bit ever changes from 0 to 1. The block then returns to mode 0.
- R4: A write of code 0x20 followed by a write of code 0xD0 sets every word whose top SECT_W address bits equal those of the 0xD0 write's `addr` to all ones. Words in other sectors keep their values.
- R5: A write of code 0x20 followed by a write of code 0xDB sets every word of the array to all ones.
- R6: Code 0xD0 or 0xDB written outside erase-armed mode has no effect on the array. A code other than 0xD0 or 0xDB written in erase-armed mode also leaves the array unchanged. In both cases the block goes to mode 0.
- R7: After a program or erase, `busy` is high for exactly BUSY_CYCLES cycles. A write while `busy` is high changes neither the mode nor the array.
- R8: Code 0xA0 enters mode 3 and latches `addr`. From then on `rdata` shows the latched word whatever `addr` does, and `verify_ok` is 1 exactly when that word is all ones.
- R9: Code 0xC0 enters mode 4 and latches `addr`. `rdata` shows the latched word, and `verify_ok` is 1 exactly when that word equals the `wdata` of the most recent program. That value is all ones after reset. In modes 0 to 2 `verify_ok` is 0.
- R10: In modes 0, 3 and 4, code 0x00 selects mode 0, and any code outside {0x00, 0x20, 0x40, 0xA0, 0xC0} also selects mode 0. Neither has any effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a command or program data |
| addr | input | ADDR_W | Word address for reads, programs, sector choice and verify capture |
| wdata | input | DATA_W | Command code on bits 7:0, or program data |
| rdata | output | DATA_W | Word at `addr`, or at the latched verify address |
| busy | output | 1 | An operation is in progress and writes are ignored |
| mode | output | 3 | Current mode: 0 read, 1 erase armed, 2 program armed, 3 erase verify, 4 program verify |
| verify_ok | output | 1 | Result of the active verify comparison |

## Verification
The bench builds the block with a 16-word, 8-bit array split into four sectors of four words, and with BUSY_CYCLES set to 3. With a memory this small, the bench can read back every word after a bulk erase, and it can place program targets on both sides of a sector boundary to show that a sector erase stays inside its sector. The short busy window keeps the run brief. It still leaves room to issue an arming code inside the window and then show that a confirm code written afterwards has no effect. A behavioural model in the bench predicts all four outputs on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_E_ARM = 3'd1,
    M_P_ARM = 3'd2,
    M_E_VFY = 3'd3,
    M_P_VFY = 3'd4
  } fmode_e;

  localparam logic [7:0] C_READ       = 8'h00;
  localparam logic [7:0] C_ARM_ERASE  = 8'h20;
  localparam logic [7:0] C_ARM_PROG   = 8'h40;
  localparam logic [7:0] C_ERASE_SECT = 8'hD0;
  localparam logic [7:0] C_ERASE_ALL  = 8'hDB;
  localparam logic [7:0] C_VFY_ERASE  = 8'hA0;
  localparam logic [7:0] C_VFY_PROG   = 8'hC0;

  // Flash programming only clears bits.
  function automatic logic [63:0] merge_program(input logic [63:0] old_w,
                                                input logic [63:0] new_w);
    return old_w & new_w;
  endfunction

  // Sector index is taken from the upper address bits.
  function automatic int unsigned sector_index(input int unsigned word_idx,
                                               input int unsigned addr_w,
                                               input int unsigned sect_w);
    return word_idx >> (addr_w - sect_w);
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  fmode_e     cur_mode,
  input  logic       accept,
  input  logic [7:0] code,
  output fmode_e     nxt_mode,
  output logic       fire_prog,
  output logic       fire_sect,
  output logic       fire_bulk,
  output logic       load_vaddr
);

  always_comb begin
    nxt_mode   = cur_mode;
    fire_prog  = 1'b0;
    fire_sect  = 1'b0;
    fire_bulk  = 1'b0;
    load_vaddr = 1'b0;
    if (accept) begin
      unique case (cur_mode)
        M_E_ARM: begin
          nxt_mode  = M_READ;
          fire_sect = (code == C_ERASE_SECT);
          fire_bulk = (code == C_ERASE_ALL);
        end
        M_P_ARM: begin
          nxt_mode  = M_READ;
          fire_prog = 1'b1;
        end
        default: begin
          case (code)
            C_ARM_ERASE: nxt_mode = M_E_ARM;
            C_ARM_PROG:  nxt_mode = M_P_ARM;
            C_VFY_ERASE: begin nxt_mode = M_E_VFY; load_vaddr = 1'b1; end
            C_VFY_PROG:  begin nxt_mode = M_P_VFY; load_vaddr = 1'b1; end
            default:     nxt_mode = M_READ;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              sect_en,
  input  logic              bulk_en,
  input  logic [ADDR_W-1:0] erase_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [WORDS-1:0][DATA_W-1:0] flat;
  logic [SECT_W-1:0]            erase_sect;

  assign erase_sect = erase_addr[ADDR_W-1 -: SECT_W];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(sector_index(w, ADDR_W, SECT_W));
    logic [DATA_W-1:0] word_q;
    logic [63:0]       merged;

    assign merged = merge_program(64'(word_q), 64'(prog_data));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (bulk_en || (sect_en && erase_sect == MY_SECT))
        word_q <= '1;
      else if (prog_en && prog_addr == ADDR_W'(w))
        word_q <= merged[DATA_W-1:0];
    end

    assign flat[w] = word_q;
  end

  assign rd_data = flat[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SECT_W      = 2,
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic [2:0]        mode,
  output logic              verify_ok
);

  fmode_e            mode_q, mode_d;
  logic [ADDR_W-1:0] vaddr_q;
  logic [DATA_W-1:0] expect_q;
  logic              accept;
  logic              prog_fire, sect_fire, bulk_fire, erase_fire, load_vaddr;
  logic              in_verify;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;

  assign accept = wr_en && !busy;

  flash_cmd_decode u_decode (
    .cur_mode   (mode_q),
    .accept     (accept),
    .code       (wdata[7:0]),
    .nxt_mode   (mode_d),
    .fire_prog  (prog_fire),
    .fire_sect  (sect_fire),
    .fire_bulk  (bulk_fire),
    .load_vaddr (load_vaddr)
  );

  assign erase_fire = sect_fire | bulk_fire;

  flash_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_fire | erase_fire),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_READ;
      vaddr_q  <= '0;
      expect_q <= '1;
    end else begin
      mode_q <= mode_d;
      if (load_vaddr) vaddr_q  <= addr;
      if (prog_fire)  expect_q <= wdata;
    end
  end

  assign in_verify = (mode_q == M_E_VFY) || (mode_q == M_P_VFY);
  assign rd_addr   = in_verify ? vaddr_q : addr;

  flash_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_en    (prog_fire),
    .prog_addr  (addr),
    .prog_data  (wdata),
    .sect_en    (sect_fire),
    .bulk_en    (bulk_fire),
    .erase_addr (addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_word)
  );

  always_comb begin
    unique case (mode_q)
      M_E_VFY: verify_ok = (rd_word == '1);
      M_P_VFY: verify_ok = (rd_word == expect_q);
      default: verify_ok = 1'b0;
    endcase
  end

  assign rdata = rd_word;
  assign mode  = mode_q;

endmodule

// File: rtl/flash_cmd_sva.sv
module flash_cmd_sva #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input logic [2:0]        mode,
  input logic              verify_ok,
  input logic              prog_fire,
  input logic              erase_fire
);

  assert_busy_after_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire || erase_fire) |=> busy);

  assert_ignore_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(mode));

  assert_prog_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> (mode == 3'd2));

  assert_erase_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |-> (mode == 3'd1));

  assert_read_after_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire || erase_fire) |=> (mode == 3'd0));

  assert_verify_flag_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    verify_ok |-> (mode == 3'd3 || mode == 3'd4));

  assert_bits_only_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && $past(mode) == 3'd0 && $stable(addr))
      |-> ((rdata & ~$past(rdata)) == '0));

endmodule

bind flash_cmd_ctrl flash_cmd_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .rdata      (rdata),
  .busy       (busy),
  .mode       (mode),
  .verify_ok  (verify_ok),
  .prog_fire  (prog_fire),
  .erase_fire (erase_fire)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SW = 2;
  localparam int BC = 3;
  localparam int NW = 1 << AW;
  localparam int PER_SECT = NW >> SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          busy;
  logic [2:0]    mode;
  logic          verify_ok;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [DW-1:0] m [NW];
  int            mm;
  int            bcnt;
  int            va;
  logic [DW-1:0] pd;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .BUSY_CYCLES(BC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .mode(mode), .verify_ok(verify_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic we, input int a, input logic [DW-1:0] d);
    bit op = 0;
    if (we && bcnt == 0) begin
      if (mm == 1) begin
        if (d == 8'hD0) begin
          op = 1;
          for (int i = 0; i < NW; i++) if (i / PER_SECT == a / PER_SECT) m[i] = '1;
        end else if (d == 8'hDB) begin
          op = 1;
          for (int i = 0; i < NW; i++) m[i] = '1;
        end
        mm = 0;
      end else if (mm == 2) begin
        m[a] = m[a] & d;
        pd   = d;
        op   = 1;
        mm   = 0;
      end else begin
        case (d)
          8'h20:   mm = 1;
          8'h40:   mm = 2;
          8'hA0:   begin mm = 3; va = a; end
          8'hC0:   begin mm = 4; va = a; end
          default: mm = 0;
        endcase
      end
    end
    if (op) bcnt = BC;
    else if (bcnt > 0) bcnt--;
  endtask

  task automatic compare_all();
    logic [DW-1:0] w;
    logic          ok;
    w  = m[(mm == 3 || mm == 4) ? va : int'(addr)];
    ok = (mm == 3) ? (w == '1) : (mm == 4) ? (w == pd) : 1'b0;
    chk("R2 rdata vs model", rdata, w);
    chk("R7 busy vs model", busy, (bcnt != 0));
    chk("R10 mode vs model", mode, mm);
    chk("R8 verify_ok vs model", verify_ok, ok);
  endtask

  task automatic step(input logic we, input int a, input logic [DW-1:0] d);
    wr_en = we; addr = AW'(a); wdata = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy === 1'b1 && n < 50) begin n++; step(1'b0, int'(addr), '0); end
  endtask

  task automatic peek(input int a, input logic [DW-1:0] exp, input string tag);
    step(1'b0, a, '0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < NW; i++) m[i] = '1;
    mm = 0; bcnt = 0; va = 0; pd = '1;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 verify_ok in reset", verify_ok, 0);
    for (int i = 0; i < NW; i++) begin
      addr = AW'(i); #1;
      chk("R1 word erased in reset", rdata, 8'hFF);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, '0);
    chk("R1 mode after release", mode, 0);

    // R3 program, then AND with a second program
    step(1'b1, 5, 8'h40); chk("R2 mode program armed", mode, 2);
    step(1'b1, 5, 8'hA5);
    wait_idle();
    peek(5, 8'hA5, "R3 first program");
    step(1'b1, 5, 8'h40); step(1'b1, 5, 8'h0F);
    wait_idle();
    peek(5, 8'h05, "R3 program ANDs bits");

    // R9 program verify
    step(1'b1, 5, 8'hC0);
    chk("R9 mode program verify", mode, 4);
    chk("R9 mismatch flagged", verify_ok, 0);
    step(1'b1, 6, 8'h40); step(1'b1, 6, 8'h3C);
    wait_idle();
    step(1'b1, 6, 8'hC0);
    step(1'b0, 0, '0);
    chk("R9 latched word", rdata, 8'h3C);
    chk("R9 match flagged", verify_ok, 1);

    // R4 sector erase: words 1 (sector 0), 5 and 6 (sector 1)
    step(1'b1, 1, 8'h00);
    step(1'b1, 1, 8'h40); step(1'b1, 1, 8'h11);
    wait_idle();
    step(1'b1, 4, 8'h20); chk("R2 mode erase armed", mode, 1);
    step(1'b1, 7, 8'hD0);
    wait_idle();
    peek(5, 8'hFF, "R4 sector word 5 erased");
    peek(6, 8'hFF, "R4 sector word 6 erased");
    peek(1, 8'h11, "R4 other sector kept");

    // R8 erase verify
    step(1'b1, 5, 8'hA0);
    step(1'b0, 1, '0);
    chk("R8 mode erase verify", mode, 3);
    chk("R8 latched erased word", rdata, 8'hFF);
    chk("R8 erased flagged", verify_ok, 1);
    step(1'b1, 1, 8'hA0);
    chk("R8 unerased word", rdata, 8'h11);
    chk("R8 unerased flagged low", verify_ok, 0);

    // R6 out-of-order steps
    step(1'b1, 1, 8'h00);
    step(1'b1, 1, 8'hD0);
    step(1'b1, 1, 8'hDB);
    chk("R6 confirm without set-up mode", mode, 0);
    peek(1, 8'h11, "R6 confirm without set-up array");
    step(1'b1, 1, 8'h20); step(1'b1, 1, 8'h55);
    chk("R6 bad confirm mode", mode, 0);
    peek(1, 8'h11, "R6 bad confirm array");

    // R7 busy window and ignored writes
    step(1'b1, 1, 8'h40); step(1'b1, 1, 8'h01);
    n = 0;
    while (busy === 1'b1 && n < 20) begin n++; step(1'b1, 2, 8'h20); end
    chk("R7 busy length", n, BC);
    step(1'b1, 2, 8'hD0);
    wait_idle();
    peek(1, 8'h01, "R7 set-up during busy ignored");
    chk("R7 mode after ignored set-up", mode, 0);

    // R5 bulk erase
    step(1'b1, 9, 8'h40); step(1'b1, 9, 8'h00);
    wait_idle();
    step(1'b1, 0, 8'h20); step(1'b1, 0, 8'hDB);
    wait_idle();
    for (int i = 0; i < NW; i++) peek(i, 8'hFF, "R5 bulk erased word");

    // R10 return to read
    step(1'b1, 3, 8'hA0); chk("R10 enter erase verify", mode, 3);
    step(1'b1, 3, 8'h77); chk("R10 undefined code to read", mode, 0);
    step(1'b1, 3, 8'hC0); chk("R10 enter program verify", mode, 4);
    step(1'b1, 3, 8'h00); chk("R10 read code to read", mode, 0);
    peek(3, 8'hFF, "R10 no array effect");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule